// File: doc/BRIEF.md
# Loadable Synchronous Up Counter with Clear

This block is a synchronous binary up counter, four bits wide by default, built to serve as one stage of a wider count. All state changes on the rising clock edge except the clear, which is asynchronous and active low. On each edge the counter does one of three things: it takes a parallel data word, it advances by one, or it keeps its value. The choice follows a fixed priority: clear first, then load, then count, then hold.

A carry output lets a higher-order stage be chained to this one. The carry is high during the cycle in which this stage is about to wrap from all ones to zero. The next stage can use it as its own count enable, so both stages change on the same edge.

Top module: `ldctr_top`

## Requirements
- R1: While `clear_n` is 0, `q` is all zeros at once, without waiting for a clock edge, whatever the values of `load`, `count_en` and `din`.
- R2: With `clear_n` at 1 and `load` at 1, a rising edge puts `din` into `q`, whatever the value of `count_en`.
- R3: With `clear_n` at 1, `load` at 0 and `count_en` at 1, a rising edge sets `q` to its previous value plus one, modulo 2^WIDTH.
- R4: With `clear_n` at 1, `load` at 0 and `count_en` at 0, a rising edge leaves `q` unchanged.
- R5: Counting from all ones (15 for WIDTH 4) gives all zeros on the next edge.
- R6: `carry_out` is 1 exactly when `q` is all ones, `count_en` is 1 and `load` is 0. It is 0 in every other case, including while `clear_n` is 0.
- R7: After `clear_n` returns to 1, `q` stays 0 until the next rising edge. That edge obeys the priority of R2 to R4.
- R8: WIDTH is a parameter with a default of 4. The carry condition is all ones across WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| load | input | 1 | Parallel load request; takes priority over counting |
| count_en | input | 1 | Count enable |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Current count value |
| carry_out | output | 1 | Cascade carry to the next stage |

## Verification
The clocked assertions take two things for granted. First, `clear_n` never changes at a rising clock edge, so the sampled value of `q` always follows the asynchronous clear cleanly. Second, `load`, `count_en` and `din` are stable around each edge.

The stimulus respects both. It drives every data and control input on the falling clock edge. It moves `clear_n` only a short time after a falling edge, well away from any rising edge. The bench starts from every value reachable by load, applies every combination of control and data word, and computes the expected count and carry arithmetically.

// File: rtl/ldctr_pkg.sv
package ldctr_pkg;

  // Action chosen for the coming clock edge (clear is handled asynchronously)
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'b00,
    ACT_COUNT = 2'b01,
    ACT_LOAD  = 2'b10
  } act_e;

endpackage

// File: rtl/ldctr_arbiter.sv
module ldctr_arbiter
  import ldctr_pkg::*;
(
  input  logic load,
  input  logic count_en,
  output act_e act
);

  // Fixed priority: load over count over hold
  always_comb begin
    if (load) begin
      act = ACT_LOAD;
    end else if (count_en) begin
      act = ACT_COUNT;
    end else begin
      act = ACT_HOLD;
    end
  end

endmodule

// File: rtl/ldctr_incr.sv
module ldctr_incr #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] inc,
  output logic             all_ones
);

  // Toggle chain: bit i flips when every lower bit is one
  logic [WIDTH-1:0] tgl;

  assign tgl[0] = 1'b1;

  genvar i;
  generate
    for (i = 1; i < WIDTH; i++) begin : g_chain
      assign tgl[i] = tgl[i-1] & cur[i-1];
    end
  endgenerate

  assign inc      = cur ^ tgl;
  assign all_ones = tgl[WIDTH-1] & cur[WIDTH-1];

endmodule

// File: rtl/ldctr_reg.sv
module ldctr_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) !clear_n |-> q == '0); // R1
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!clear_n) !en |=> $stable(q)); // R4

endmodule

// File: rtl/ldctr_top.sv
module ldctr_top
  import ldctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load,
  input  logic             count_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  act_e             act;
  logic [WIDTH-1:0] inc_val;
  logic             at_top;
  logic [WIDTH-1:0] nxt;
  logic             upd_en;

  ldctr_arbiter u_arb (
    .load     (load),
    .count_en (count_en),
    .act      (act)
  );

  ldctr_incr #(.WIDTH(WIDTH)) u_inc (
    .cur      (q),
    .inc      (inc_val),
    .all_ones (at_top)
  );

  // Next-state selection
  always_comb begin
    upd_en = 1'b0;
    nxt    = q;
    case (act)
      ACT_LOAD: begin
        upd_en = 1'b1;
        nxt    = din;
      end
      ACT_COUNT: begin
        upd_en = 1'b1;
        nxt    = inc_val;
      end
      default: begin
        upd_en = 1'b0;
        nxt    = q;
      end
    endcase
  end

  ldctr_reg #(.WIDTH(WIDTH)) u_reg (
    .clk     (clk),
    .clear_n (clear_n),
    .en      (upd_en),
    .d       (nxt),
    .q       (q)
  );

  assign carry_out = at_top & (act == ACT_COUNT);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!clear_n) load |=> q == $past(din)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clear_n) (!load && count_en) |=> q == WIDTH'($past(q) + 1'b1)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clear_n) (!load && count_en && q == ALL_ONES) |=> q == '0); // R5
  AST_CARRY_THEN_ZERO: assert property (@(posedge clk) disable iff (!clear_n) carry_out |=> q == '0); // R6
  AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (!clear_n) carry_out |-> q == ALL_ONES); // R8

endmodule

// File: tb/tb_ldctr_top.sv
module tb_ldctr_top;

  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         clear_n = 1'b1;
  logic         load = 1'b0;
  logic         count_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ldctr_top #(.WIDTH(W)) dut (
    .clk       (clk),
    .clear_n   (clear_n),
    .load      (load),
    .count_en  (count_en),
    .din       (din),
    .q         (q),
    .carry_out (carry_out)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    // Reset state: clear asserted away from any rising edge
    #2 clear_n = 1'b0;
    #1;
    chk("R1 reset q", int'(q), 0);
    chk("R6 reset carry", int'(carry_out), 0);
    @(negedge clk);
    load = 1'b1; count_en = 1'b1; din = 4'd9;
    tick();
    chk("R1 clear beats load/count", int'(q), 0);
    chk("R6 no carry in clear", int'(carry_out), 0);

    // Release clear mid-cycle; value holds until next edge, which loads (R7)
    #1 clear_n = 1'b1;
    #1;
    chk("R7 zero before edge", int'(q), 0);
    @(negedge clk);
    chk("R7 first edge loads", int'(q), 9);

    // Exhaustive sweep: start value x control x data
    for (int v = 0; v < N; v++) begin
      for (int c = 0; c < 4; c++) begin
        for (int d = 0; d < N; d++) begin
          int exp_q;
          int exp_c;
          load = 1'b1; count_en = d[0]; din = W'(v);
          tick();
          chk("R2 load regardless of count", int'(q), v);
          load = c[1]; count_en = c[0]; din = W'(d);
          exp_c = (!c[1] && c[0] && v == N - 1) ? 1 : 0;
          #1;
          chk("R6 R8 carry", int'(carry_out), exp_c);
          if (c[1])      exp_q = d;
          else if (c[0]) exp_q = (v + 1) % N;
          else           exp_q = v;
          @(negedge clk);
          if (c[1])           chk("R2 load", int'(q), exp_q);
          else if (!c[0])     chk("R4 hold", int'(q), exp_q);
          else if (v == N - 1) chk("R5 wrap", int'(q), exp_q);
          else                chk("R3 increment", int'(q), exp_q);
        end
      end
    end

    // Long count run through a wrap
    load = 1'b1; count_en = 1'b0; din = 4'd13;
    tick();
    load = 1'b0; count_en = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk("R3 R5 run", int'(q), (13 + k) % N);
    end

    // Asynchronous clear mid-cycle while counting
    #1 clear_n = 1'b0;
    #1;
    chk("R1 async clear", int'(q), 0);
    @(negedge clk);
    // Release with count only: next edge counts from zero (R7)
    load = 1'b0; count_en = 1'b1;
    #1 clear_n = 1'b1;
    #1;
    chk("R7 holds zero after release", int'(q), 0);
    @(negedge clk);
    chk("R7 release then count", int'(q), 1);
    count_en = 1'b0;
    tick();
    chk("R4 hold after release", int'(q), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule